// File: doc/BRIEF.md
# Calendar Update Engine with Alarm

This block keeps a ten-byte set of time, calendar and alarm values and moves the time forward by one second each time its update strobe is high at a clock edge. It carries seconds, minutes, hours, day of week, day of month, month and a two-digit year. It counts in either plain binary or packed BCD, and it keeps the hour in either 24-hour form or 12-hour form with a PM flag. An optional daylight-saving mode adds the spring-forward and fall-back jumps.

After each advance the new hours, minutes and seconds are compared with three alarm bytes. The top two bits of an alarm byte, when both set, make that byte a wildcard. A full match raises a one-cycle alarm pulse at the same time as the advanced time appears. A byte-wide write port lets the host load any of the ten bytes. A write always beats an increment that falls in the same cycle.

Top module: `cal_update_engine`

## Requirements
- R1: After reset the bytes at offsets 0..9 read 00,00,00,00,00,00,01,01,01,00 (day of week, day of month and month hold 1), and `alarm_o` is low.
- R2: On a strobe, seconds and minutes wrap from 59 to 0 and carry onward. The carry reaches the hour, and 24-hour hours wrap 23 to 0. Values are BCD (59 = 0x59) when `bin_mode_i`=0 and binary (59 = 0x3B) when `bin_mode_i`=1.
- R3: With `hr24_i`=0 the hour byte holds 1..12 in bits 6:0 and bit 7 = PM. 11:59:59 AM steps to 12:00:00 PM (BCD 0x92). 12:59:59 steps to 1:00:00 with bit 7 unchanged. 11:59:59 PM steps to 12:00:00 AM of the next day.
- R4: The day of week runs 1..7 (1 = Sunday) and steps whenever the day of month steps. Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year is a multiple of four, else 28. The year wraps 99 to 0 after December 31.
- R5: With `dst_en_i`=1, in month 4 on a Sunday with day of month 1..7, the time 1:59:59 AM steps straight to 3:00:00. With `dst_en_i`=0 it steps to 2:00:00.
- R6: With `dst_en_i`=1, in month 10 on a Sunday with day of month 25 or later, the first arrival at 1:59:59 AM steps back to 1:00:00. The second arrival that day steps on to 2:00:00.
- R7: `alarm_o` is high for exactly the cycle after a strobe that was not overridden by a write. It is high when each of the new seconds, minutes and hours equals its alarm byte (offsets 1, 3, 5), or when that alarm byte is 0xC0..0xFF. With all three alarm bytes set as wildcards it is high after every strobe.
- R8: A write with `wr_addr_i` in 0..9 is visible on `regs_o` in the next cycle. The offsets are seconds, seconds alarm, minutes, minutes alarm, hours, hours alarm, day of week, day of month, month, year. Byte k sits in `regs_o[8k+7:8k]`. Writes to offsets 10..15 change nothing. Without a strobe or a write, all bytes hold.
- R9: When a write to offsets 0..9 and a strobe occur in the same cycle, the write is applied, no byte advances and `alarm_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second update strobe |
| bin_mode_i | input | 1 | 1 = binary encoding, 0 = BCD |
| hr24_i | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM bit |
| dst_en_i | input | 1 | Enables daylight-saving jumps |
| wr_en_i | input | 1 | Host byte write enable |
| wr_addr_i | input | 4 | Byte offset of the write |
| wr_data_i | input | 8 | Byte to write |
| regs_o | output | 80 | All ten bytes, byte k at bits 8k+7:8k |
| alarm_o | output | 1 | One-cycle alarm match pulse |

## Verification
The assertions assume that the host loads only legal values for the current encoding and hour format. They also assume that the mode bits do not change between a write and the strobes that depend on it, because a byte written in one encoding has no meaning in the other. The stimulus therefore reloads every time byte after each mode change and writes only in-range values. The day-of-week range check assumes that the day of week was written as 1..7 beforehand. The one open-ended stretch of strobes starts from such a consistent state.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int NBYTES  = 10;
    localparam int BYTE_W  = 8;
    localparam int VAL_W   = 7;
    localparam int ADDR_W  = 4;
    localparam int NFIELDS = 3;

    localparam int OFS_SEC  = 0;
    localparam int OFS_ASEC = 1;
    localparam int OFS_MIN  = 2;
    localparam int OFS_AMIN = 3;
    localparam int OFS_HR   = 4;
    localparam int OFS_AHR  = 5;
    localparam int OFS_DOW  = 6;
    localparam int OFS_DOM  = 7;
    localparam int OFS_MON  = 8;
    localparam int OFS_YR   = 9;

    typedef logic [NBYTES-1:0][BYTE_W-1:0] cal_bytes_t;

    typedef struct packed {
        cal_bytes_t b;
        logic       fb;
        logic       al;
    } eng_st_t;

    function automatic logic [VAL_W-1:0] dec(input logic [BYTE_W-1:0] v, input logic bin);
        if (bin) return v[VAL_W-1:0];
        return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
    endfunction

    function automatic logic [BYTE_W-1:0] enc(input logic [VAL_W-1:0] v, input logic bin);
        logic [VAL_W-1:0] tens, ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        if (bin) return {1'b0, v};
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [VAL_W-1:0] month_len(input logic [VAL_W-1:0] mo, input logic [VAL_W-1:0] yr);
        case (mo)
            7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
            7'd2:                    return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            default:                 return 7'd31;
        endcase
    endfunction

    function automatic cal_bytes_t reset_bytes();
        cal_bytes_t r;
        r = '0;
        r[OFS_DOW] = 8'h01;
        r[OFS_DOM] = 8'h01;
        r[OFS_MON] = 8'h01;
        return r;
    endfunction
endpackage

// File: rtl/cal_step.sv
module cal_step
    import cal_pkg::*;
(
    input  cal_bytes_t cur_i,
    input  logic       bin_i,
    input  logic       h24_i,
    input  logic       dst_i,
    input  logic       fb_done_i,
    output cal_bytes_t nxt_o,
    output logic       fb_set_o,
    output logic       day_roll_o
);
    logic [VAL_W-1:0]  s_v, m_v, h_v, h12_v, dw_v, dd_v, mo_v, yy_v;
    logic              pm_v, at_edge_v, spring_v, fall_v;
    logic [BYTE_W-1:0] hb_v;

    always_comb begin
        nxt_o      = cur_i;
        fb_set_o   = 1'b0;
        day_roll_o = 1'b0;
        pm_v       = 1'b0;
        hb_v       = '0;
        h12_v      = '0;

        s_v  = dec(cur_i[OFS_SEC], bin_i);
        m_v  = dec(cur_i[OFS_MIN], bin_i);
        dw_v = dec(cur_i[OFS_DOW], bin_i);
        dd_v = dec(cur_i[OFS_DOM], bin_i);
        mo_v = dec(cur_i[OFS_MON], bin_i);
        yy_v = dec(cur_i[OFS_YR],  bin_i);
        if (h24_i) begin
            h_v = dec(cur_i[OFS_HR], bin_i);
        end else begin
            h12_v = dec({1'b0, cur_i[OFS_HR][6:0]}, bin_i);
            h_v   = ((h12_v == 7'd12) ? 7'd0 : h12_v) + (cur_i[OFS_HR][7] ? 7'd12 : 7'd0);
        end

        at_edge_v = (h_v == 7'd1) && (m_v == 7'd59) && (s_v == 7'd59);
        spring_v  = dst_i && at_edge_v && (mo_v == 7'd4)  && (dw_v == 7'd1) && (dd_v <= 7'd7);
        fall_v    = dst_i && at_edge_v && (mo_v == 7'd10) && (dw_v == 7'd1) && (dd_v >= 7'd25) && !fb_done_i;

        if (spring_v) begin
            h_v = 7'd3; m_v = '0; s_v = '0;
        end else if (fall_v) begin
            h_v = 7'd1; m_v = '0; s_v = '0;
            fb_set_o = 1'b1;
        end else begin
            s_v = s_v + 7'd1;
            if (s_v == 7'd60) begin
                s_v = '0;
                m_v = m_v + 7'd1;
                if (m_v == 7'd60) begin
                    m_v = '0;
                    h_v = h_v + 7'd1;
                    if (h_v == 7'd24) begin
                        h_v        = '0;
                        day_roll_o = 1'b1;
                    end
                end
            end
        end

        if (day_roll_o) begin
            dw_v = (dw_v >= 7'd7) ? 7'd1 : dw_v + 7'd1;
            if (dd_v >= month_len(mo_v, yy_v)) begin
                dd_v = 7'd1;
                if (mo_v >= 7'd12) begin
                    mo_v = 7'd1;
                    yy_v = (yy_v >= 7'd99) ? 7'd0 : yy_v + 7'd1;
                end else begin
                    mo_v = mo_v + 7'd1;
                end
            end else begin
                dd_v = dd_v + 7'd1;
            end
        end

        nxt_o[OFS_SEC] = enc(s_v,  bin_i);
        nxt_o[OFS_MIN] = enc(m_v,  bin_i);
        nxt_o[OFS_DOW] = enc(dw_v, bin_i);
        nxt_o[OFS_DOM] = enc(dd_v, bin_i);
        nxt_o[OFS_MON] = enc(mo_v, bin_i);
        nxt_o[OFS_YR]  = enc(yy_v, bin_i);
        if (h24_i) begin
            nxt_o[OFS_HR] = enc(h_v, bin_i);
        end else begin
            pm_v  = (h_v >= 7'd12);
            h12_v = h_v % 7'd12;
            if (h12_v == 7'd0) h12_v = 7'd12;
            hb_v  = enc(h12_v, bin_i);
            nxt_o[OFS_HR] = {pm_v, hb_v[6:0]};
        end
    end
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
    import cal_pkg::*;
(
    input  logic [NFIELDS-1:0][BYTE_W-1:0] now_i,
    input  logic [NFIELDS-1:0][BYTE_W-1:0] alm_i,
    output logic                           hit_o
);
    logic [NFIELDS-1:0] field_ok;

    for (genvar k = 0; k < NFIELDS; k++) begin : g_field
        assign field_ok[k] = (alm_i[k][7:6] == 2'b11) || (alm_i[k] == now_i[k]);
    end

    assign hit_o = &field_ok;
endmodule

// File: rtl/cal_update_engine.sv
module cal_update_engine
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bin_mode_i,
    input  logic              hr24_i,
    input  logic              dst_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic [79:0]       regs_o,
    output logic              alarm_o
);
    eng_st_t    st_d, st_q;
    cal_bytes_t step_nxt;
    logic       fb_set, day_roll, alarm_hit, wr_hit;
    logic [NFIELDS-1:0][BYTE_W-1:0] now_f, alm_f;

    assign wr_hit = wr_en_i && (wr_addr_i < ADDR_W'(NBYTES));

    cal_step u_step (
        .cur_i      (st_q.b),
        .bin_i      (bin_mode_i),
        .h24_i      (hr24_i),
        .dst_i      (dst_en_i),
        .fb_done_i  (st_q.fb),
        .nxt_o      (step_nxt),
        .fb_set_o   (fb_set),
        .day_roll_o (day_roll)
    );

    assign now_f = {step_nxt[OFS_HR], step_nxt[OFS_MIN], step_nxt[OFS_SEC]};
    assign alm_f = {st_q.b[OFS_AHR], st_q.b[OFS_AMIN], st_q.b[OFS_ASEC]};

    cal_alarm u_alarm (
        .now_i (now_f),
        .alm_i (alm_f),
        .hit_o (alarm_hit)
    );

    always_comb begin
        st_d    = st_q;
        st_d.al = 1'b0;
        if (wr_hit) begin
            st_d.b[wr_addr_i] = wr_data_i;
        end else if (tick_i) begin
            st_d.b  = step_nxt;
            st_d.al = alarm_hit;
            if (fb_set)        st_d.fb = 1'b1;
            else if (day_roll) st_d.fb = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.b  <= reset_bytes();
            st_q.fb <= 1'b0;
            st_q.al <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o  = st_q.b;
    assign alarm_o = st_q.al;

    AST_ALARM_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> $past(tick_i && !wr_hit)); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en_i) |=> $stable(regs_o)); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (st_q.b[$past(wr_addr_i)] == $past(wr_data_i)) && !alarm_o); // R9
    AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_hit && (regs_o[55:48] >= 8'd1) && (regs_o[55:48] <= 8'd7))
        |=> (regs_o[55:48] >= 8'd1) && (regs_o[55:48] <= 8'd7)); // R4
endmodule

// File: tb/cal_update_engine_bench.sv
module cal_update_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, bin_m = 1'b0, h24_m = 1'b1, dst_m = 1'b0, we = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdat = '0;
    logic [79:0] regs;
    logic        alarm;

    int compared = 0;
    int mismatched = 0;

    logic [7:0] mb [10];
    bit         mfb;
    bit         exp_al;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_update_engine u_cal_update_engine (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bin_mode_i(bin_m), .hr24_i(h24_m),
        .dst_en_i(dst_m), .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(wdat),
        .regs_o(regs), .alarm_o(alarm)
    );

    function automatic int dv(logic [7:0] b);
        if (bin_m) return int'(b);
        return int'(b >> 4) * 10 + int'(b & 8'h0f);
    endfunction

    function automatic logic [7:0] ev(int v);
        if (bin_m) return 8'(v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_tick();
        int h, tod, dw, dd, mo, yr, hh;
        if (h24_m) h = dv(mb[4]);
        else h = (dv(mb[4] & 8'h7f) % 12) + (mb[4][7] ? 12 : 0);
        tod = h * 3600 + dv(mb[2]) * 60 + dv(mb[0]);
        dw = dv(mb[6]); dd = dv(mb[7]); mo = dv(mb[8]); yr = dv(mb[9]);
        if (dst_m && tod == 7199 && mo == 4 && dw == 1 && dd <= 7) tod = 10800;
        else if (dst_m && tod == 7199 && mo == 10 && dw == 1 && dd >= 25 && !mfb) begin
            tod = 3600; mfb = 1;
        end else begin
            tod++;
            if (tod == 86400) begin
                tod = 0; mfb = 0;
                dw = (dw % 7) + 1;
                if (dd == mdays(mo, yr)) begin
                    dd = 1;
                    if (mo == 12) begin mo = 1; yr = (yr + 1) % 100; end
                    else mo++;
                end else dd++;
            end
        end
        hh = tod / 3600;
        mb[0] = ev(tod % 60);
        mb[2] = ev((tod / 60) % 60);
        if (h24_m) mb[4] = ev(hh);
        else mb[4] = ev((hh % 12 == 0) ? 12 : hh % 12) | (hh >= 12 ? 8'h80 : 8'h00);
        mb[6] = ev(dw); mb[7] = ev(dd); mb[8] = ev(mo); mb[9] = ev(yr);
        exp_al = ((mb[1][7:6] == 2'b11) || mb[1] == mb[0]) &&
                 ((mb[3][7:6] == 2'b11) || mb[3] == mb[2]) &&
                 ((mb[5][7:6] == 2'b11) || mb[5] == mb[4]);
    endtask

    task automatic compare(string tag);
        bit bad = 0;
        compared++;
        for (int i = 0; i < 10; i++) begin
            if (regs[i*8 +: 8] !== mb[i]) begin
                if (!bad) mismatched++;
                bad = 1;
                $display("FAIL %s byte %0d actual %02h expected %02h at %0t", tag, i, regs[i*8 +: 8], mb[i], $time);
            end
        end
        if (alarm !== exp_al) begin
            if (!bad) mismatched++;
            $display("FAIL %s alarm actual %0b expected %0b at %0t", tag, alarm, exp_al, $time);
        end
    endtask

    task automatic step(bit t, bit w, logic [3:0] a, logic [7:0] d, string tag);
        @(negedge clk);
        tick = t; we = w; addr = a; wdat = d;
        exp_al = 0;
        if (w && a < 10) mb[a] = d;
        else if (t) model_tick();
        @(posedge clk);
        #1;
        compare(tag);
        @(negedge clk);
        tick = 0; we = 0;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d, string tag);
        step(0, 1, a, d, tag);
    endtask

    task automatic tk(int n, string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, tag);
    endtask

    task automatic load(logic [7:0] hr, logic [7:0] mi, logic [7:0] se, logic [7:0] dw,
                        logic [7:0] dd, logic [7:0] mo, logic [7:0] yr, string tag);
        wr(4, hr, tag); wr(2, mi, tag); wr(0, se, tag); wr(6, dw, tag);
        wr(7, dd, tag); wr(8, mo, tag); wr(9, yr, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        mb = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
        mfb = 0; exp_al = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        compare("R1 reset");

        // R8: out-of-range offset ignored, then each offset lands
        wr(12, 8'h55, "R8 ignored offset");
        wr(15, 8'hAA, "R8 ignored offset");
        wr(1, 8'h33, "R8 alarm byte");
        wr(1, 8'h00, "R8 alarm byte");

        // R2/R4 BCD 24h: year wrap at end of December
        bin_m = 0; h24_m = 1; dst_m = 0;
        load(8'h23, 8'h59, 8'h58, 8'h07, 8'h31, 8'h12, 8'h99, "R8 load");
        tk(3, "R2 R4 BCD rollover");

        // R2/R4 binary: leap February
        bin_m = 1;
        load(8'h17, 8'h3B, 8'h3A, 8'h03, 8'h1C, 8'h02, 8'h04, "R8 load");
        tk(3, "R4 leap Feb28");
        load(8'h17, 8'h3B, 8'h3B, 8'h03, 8'h1D, 8'h02, 8'h04, "R8 load");
        tk(2, "R4 leap Feb29");
        load(8'h17, 8'h3B, 8'h3B, 8'h03, 8'h1C, 8'h02, 8'h03, "R8 load");
        tk(2, "R4 common Feb28");
        load(8'h17, 8'h3B, 8'h3B, 8'h03, 8'h1E, 8'h04, 8'h03, "R8 load");
        tk(2, "R4 30-day month");
        load(8'h05, 8'h3B, 8'h30, 8'h01, 8'h05, 8'h06, 8'h20, "R8 load");
        tk(12, "R2 binary minute carry");

        // R3 12-hour
        bin_m = 0; h24_m = 0;
        load(8'h11, 8'h59, 8'h59, 8'h02, 8'h10, 8'h05, 8'h21, "R8 load");
        tk(2, "R3 noon");
        load(8'h92, 8'h59, 8'h59, 8'h02, 8'h10, 8'h05, 8'h21, "R8 load");
        tk(2, "R3 12PM to 1PM");
        load(8'h12, 8'h59, 8'h59, 8'h02, 8'h10, 8'h05, 8'h21, "R8 load");
        tk(2, "R3 12AM to 1AM");
        load(8'h91, 8'h59, 8'h59, 8'h02, 8'h10, 8'h05, 8'h21, "R8 load");
        tk(2, "R3 midnight");
        bin_m = 1;
        load(8'h8B, 8'h3B, 8'h3B, 8'h02, 8'h0A, 8'h05, 8'h15, "R8 load");
        tk(2, "R3 binary midnight");

        // R5 spring forward
        bin_m = 0; h24_m = 1; dst_m = 1;
        load(8'h01, 8'h59, 8'h58, 8'h01, 8'h05, 8'h04, 8'h24, "R8 load");
        tk(3, "R5 spring jump");
        dst_m = 0;
        load(8'h01, 8'h59, 8'h58, 8'h01, 8'h05, 8'h04, 8'h24, "R8 load");
        tk(3, "R5 no jump when disabled");
        dst_m = 1;
        load(8'h01, 8'h59, 8'h58, 8'h01, 8'h12, 8'h04, 8'h24, "R8 load");
        tk(3, "R5 second week no jump");

        // R6 fall back, once
        h24_m = 0;
        load(8'h01, 8'h59, 8'h58, 8'h01, 8'h27, 8'h10, 8'h24, "R8 load");
        tk(3603, "R6 fall back once");

        // R7 alarm
        h24_m = 1; dst_m = 0;
        load(8'h10, 8'h00, 8'h00, 8'h03, 8'h08, 8'h03, 8'h25, "R8 load");
        wr(5, 8'h10, "R7 load"); wr(3, 8'h00, "R7 load"); wr(1, 8'h03, "R7 load");
        tk(5, "R7 exact match");
        wr(5, 8'hC0, "R7 load"); wr(3, 8'hFF, "R7 load"); wr(1, 8'h10, "R7 load");
        tk(130, "R7 wildcard hour minute");
        wr(1, 8'hC5, "R7 load");
        tk(4, "R7 all wildcard");

        // R9 write wins over tick
        step(1, 1, 0, 8'h30, "R9 write suppresses tick");
        step(1, 1, 9, 8'h44, "R9 write suppresses tick");
        step(1, 1, 12, 8'h00, "R8 ignored write lets tick through");
        tk(2, "R9 resume");

        // mixed strobes with idle cycles
        bin_m = 1;
        load(8'h16, 8'h3A, 8'h00, 8'h05, 8'h1E, 8'h0C, 8'h63, "R8 load");
        wr(1, 8'h0F, "R7 load"); wr(3, 8'hC0, "R7 load"); wr(5, 8'hC0, "R7 load");
        for (int i = 0; i < 1500; i++) step(bit'($urandom_range(0, 1)), 0, 0, 0, "R2 R7 mixed");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule